// File: doc/BRIEF.md
# Multichannel Hit Merger and Framer

This block gathers hit words from sixteen independent per-channel feature extractors and merges them into a single 32-bit output stream. Each channel presents a charge value and a time value. A small FIFO for that channel accepts the pair. The merger then builds a self-describing hit word that carries the channel number, so every channel can share one stream. A round-robin arbiter decides which non-empty channel supplies the next word. No channel can therefore lock out the others.

When a readout window opens, the control logic pulses `win_start_i`. The merger then schedules one flagged header word. That header carries the module slot number and the hit-payload type code, and it goes out ahead of any hit accepted from that pulse onward. A receiver separates headers from hits by bit 31 alone.

The output side is a valid/ready stream. A word is transferred on a rising edge where `out_valid_o` and `out_ready_i` are both high. While the sink holds `out_ready_i` low, the offered word stays fixed. On the input side, `in_ready_o` reports that a channel FIFO has room. A hit that is offered while its FIFO is full is discarded, and it sets that channel's sticky overflow bit.

Top module: `hit_merger`

## Requirements
- R1: During and right after reset, `out_valid_o` is 0, every `ovf_o` bit is 0, and every `in_ready_o` bit is 1.
- R2: A header word has bit 31 = 1, bits [30:15] = 0x0001, bits [14:5] = 0, and bits [4:0] equal to `slot_i` as sampled on the edge where the header is loaded into the output register.
- R3: A hit word has bit 31 = 0, bits [30:17] = time, bits [16:13] = channel number, and bits [12:0] = charge.
- R4: After a `win_start_i` pulse, the next word loaded into the output register is the header. It therefore precedes every hit accepted on or after the pulse. Further pulses while a header is still waiting produce no additional header.
- R5: Hits are granted in round-robin order. After reset the search starts at channel 0. After a grant to channel c, the search starts at channel c+1, wrapping from 15 to 0.
- R6: Each channel buffers up to FIFO_DEPTH hits. `in_ready_o[c]` is 1 exactly when the FIFO has room. A hit offered while the FIFO is full is dropped and never appears on the output.
- R7: A dropped hit sets `ovf_o[c]`, and that bit stays set until reset.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o` and `out_data_o` do not change.
- R9: Hits from one channel leave in the order they were accepted.
- R10: The output register reloads on every edge where it is empty or its word is taken. It therefore sustains one word per cycle while `out_ready_i` is high and data is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_i | input | 5 | Module slot number (legal 3 to 20) placed in headers |
| win_start_i | input | 1 | Single-cycle pulse marking the start of a readout window |
| in_valid_i | input | NUM_CH | Per-channel hit offer |
| in_ready_o | output | NUM_CH | Per-channel FIFO has room |
| in_q_i | input | NUM_CH*13 | Per-channel charge values, channel c at bits [13c+12:13c] |
| in_t_i | input | NUM_CH*14 | Per-channel time values, channel c at bits [14c+13:14c] |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Sink accepts the output word |
| out_data_o | output | 32 | Header or hit word |
| ovf_o | output | NUM_CH | Sticky per-channel drop flags |

## Verification
On every cycle, the assertions check four things: the held word stays stable under back-pressure, the header fields are constant, the overflow bits never clear, and a waiting header wins the next output load. They also check that each FIFO never exceeds its depth, never pops while empty, and that at most one channel is granted. Only the bench scenarios can show the order of the whole stream: round-robin rotation across channels, per-channel ordering, a single header for repeated pulses, and exactly which hit is lost on overflow. The bench compares these against a behavioural queue model on every clock.

// File: rtl/hm_pkg.sv
package hm_pkg;
  localparam int HIT_Q_W   = 13;
  localparam int HIT_T_W   = 14;
  localparam int HIT_CH_W  = 4;
  localparam int SLOT_W    = 5;
  localparam int WORD_W    = 32;
  localparam int PAYLOAD_W = HIT_T_W + HIT_Q_W;
  localparam logic [15:0] PTYPE_HIT = 16'h0001;

  typedef logic [WORD_W-1:0]    word_t;
  typedef logic [PAYLOAD_W-1:0] payload_t;

  // flagged header: flag, payload type, zero gap, slot
  function automatic word_t hdr_word(input logic [SLOT_W-1:0] slot);
    return {1'b1, PTYPE_HIT, 10'b0, slot};
  endfunction

  // hit: flag clear, time, channel, charge (payload holds {time, charge})
  function automatic word_t hit_word(input logic [HIT_CH_W-1:0] ch, input payload_t p);
    return {1'b0, p[PAYLOAD_W-1:HIT_Q_W], ch, p[HIT_Q_W-1:0]};
  endfunction
endpackage

// File: rtl/hm_chan_fifo.sv
module hm_chan_fifo #(
  parameter int W     = 27,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R6
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R9
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/hm_rr_arb.sv
module hm_rr_arb #(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req_i,
  input  logic                 take_i,
  output logic [N-1:0]         gnt_o,
  output logic [$clog2(N)-1:0] idx_o,
  output logic                 any_o
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q;

  always_comb begin
    int j;
    any_o = 1'b0;
    idx_o = '0;
    for (int k = 1; k <= N; k++) begin
      j = (int'(ptr_q) + k) % N;
      if (!any_o && req_i[j]) begin
        any_o = 1'b1;
        idx_o = IW'(j);
      end
    end
  end

  assign gnt_o = any_o ? ({{(N-1){1'b0}}, 1'b1} << idx_o) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ptr_q <= IW'(N - 1);
    else if (take_i && any_o) ptr_q <= idx_o;
  end

  // R5
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));
endmodule

// File: rtl/hit_merger.sv
module hit_merger
  import hm_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SLOT_W-1:0]         slot_i,
  input  logic                      win_start_i,
  input  logic [NUM_CH-1:0]         in_valid_i,
  output logic [NUM_CH-1:0]         in_ready_o,
  input  logic [NUM_CH*HIT_Q_W-1:0] in_q_i,
  input  logic [NUM_CH*HIT_T_W-1:0] in_t_i,
  output logic                      out_valid_o,
  input  logic                      out_ready_i,
  output logic [WORD_W-1:0]         out_data_o,
  output logic [NUM_CH-1:0]         ovf_o
);
  localparam int IW = $clog2(NUM_CH);

  logic [NUM_CH-1:0] full, empty, pop, drop, gnt;
  payload_t          head [NUM_CH];
  logic [IW-1:0]     gidx;
  logic              any_req, load, take_hit;
  logic              hdr_pend_q, out_valid_q;
  word_t             out_data_q;
  logic [NUM_CH-1:0] ovf_q;

  assign load     = !out_valid_q || out_ready_i;
  assign take_hit = load && !hdr_pend_q && any_req;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign pop[c]  = take_hit && gnt[c];
    assign drop[c] = in_valid_i[c] && full[c];
    hm_chan_fifo #(.W(PAYLOAD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (in_valid_i[c]),
      .pop_i  (pop[c]),
      .data_i ({in_t_i[c*HIT_T_W +: HIT_T_W], in_q_i[c*HIT_Q_W +: HIT_Q_W]}),
      .data_o (head[c]),
      .full_o (full[c]),
      .empty_o(empty[c])
    );
  end

  hm_rr_arb #(.N(NUM_CH)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (~empty),
    .take_i(take_hit),
    .gnt_o (gnt),
    .idx_o (gidx),
    .any_o (any_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_pend_q  <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      ovf_q       <= '0;
    end else begin
      ovf_q <= ovf_q | drop;
      if (load) begin
        if (hdr_pend_q) begin
          out_valid_q <= 1'b1;
          out_data_q  <= hdr_word(slot_i);
        end else if (any_req) begin
          out_valid_q <= 1'b1;
          out_data_q  <= hit_word(HIT_CH_W'(gidx), head[gidx]);
        end else begin
          out_valid_q <= 1'b0;
        end
      end
      if (win_start_i)             hdr_pend_q <= 1'b1;
      else if (load && hdr_pend_q) hdr_pend_q <= 1'b0;
    end
  end

  assign in_ready_o  = ~full;
  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
  assign ovf_o       = ovf_q;

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o & $past(ovf_o)) == $past(ovf_o));
  // R2
  hdr_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_data_o[31] |-> out_data_o[30:5] == {PTYPE_HIT, 10'b0});
  // R4
  hdr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_pend_q && (!out_valid_o || out_ready_i) |=> out_valid_o && out_data_o[31]);
endmodule

// File: tb/hit_merger_test.sv
module hit_merger_test;
  localparam int N = 16;
  localparam int D = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      slot = 5'd3;
  logic            win_start = 1'b0;
  logic [N-1:0]    in_valid = '0;
  logic [N-1:0]    in_ready;
  logic [N*13-1:0] in_q = '0;
  logic [N*14-1:0] in_t = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [31:0]     out_data;
  logic [N-1:0]    ovf;

  always #10 clk = ~clk;

  hit_merger #(.NUM_CH(N), .FIFO_DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .slot_i(slot), .win_start_i(win_start),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_q_i(in_q), .in_t_i(in_t),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .ovf_o(ovf)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_hdr(input logic [4:0] s);
    return 32'h8000_0000 | (32'h1 << 15) | 32'(s);
  endfunction

  function automatic logic [31:0] exp_hit(input int ch, input int q, input int t);
    return (32'(t) << 17) | (32'(ch) << 13) | 32'(q);
  endfunction

  // behavioural reference: per-channel queues of {t,q}
  logic [26:0]  mq [N][$];
  bit           m_valid, m_pend, m_load;
  logic [31:0]  m_data;
  int           m_ptr, m_pick;
  logic [N-1:0] m_ovf, m_full;
  logic [26:0]  m_p;
  logic [31:0]  got [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < N; c++) mq[c].delete();
      m_valid = 0; m_pend = 0; m_data = '0; m_ptr = N - 1; m_ovf = '0;
    end else begin
      if (out_valid && out_ready) got.push_back(out_data);
      for (int c = 0; c < N; c++) m_full[c] = (mq[c].size() >= D);
      m_load = !m_valid || out_ready;
      if (m_load) begin
        if (m_pend) begin
          m_data = exp_hdr(slot); m_valid = 1; m_pend = 0;
        end else begin
          m_pick = -1;
          for (int k = 1; k <= N; k++)
            if (m_pick < 0 && mq[(m_ptr + k) % N].size() > 0) m_pick = (m_ptr + k) % N;
          if (m_pick >= 0) begin
            m_p = mq[m_pick].pop_front();
            m_data = exp_hit(m_pick, int'(m_p[12:0]), int'(m_p[26:13]));
            m_valid = 1; m_ptr = m_pick;
          end else m_valid = 0;
        end
      end
      if (win_start) m_pend = 1;
      for (int c = 0; c < N; c++)
        if (in_valid[c]) begin
          if (m_full[c]) m_ovf[c] = 1'b1;
          else mq[c].push_back({in_t[c*14 +: 14], in_q[c*13 +: 13]});
        end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [N-1:0] rdy;
      for (int c = 0; c < N; c++) rdy[c] = (mq[c].size() < D);
      chk("R10 out_valid vs model", 64'(out_valid), 64'(m_valid));
      if (m_valid) chk("R3 out_data vs model", 64'(out_data), 64'(m_data));
      chk("R7 ovf vs model", 64'(ovf), 64'(m_ovf));
      chk("R6 in_ready vs model", 64'(in_ready), 64'(rdy));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic idle();
    in_valid = '0; win_start = 1'b0;
  endtask

  task automatic offer(input int c, input int q, input int t);
    in_valid[c] = 1'b1;
    in_q[c*13 +: 13] = 13'(q);
    in_t[c*14 +: 14] = 14'(t);
  endtask

  task automatic do_reset();
    tick(); rst_n = 1'b0; idle(); out_ready = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    got.delete();
  endtask

  initial begin
    logic [31:0] held;
    do_reset();
    // R1 reset state
    chk("R1 out_valid after reset", 64'(out_valid), 64'd0);
    chk("R1 ovf after reset", 64'(ovf), 64'd0);
    chk("R1 in_ready after reset", 64'(in_ready), 64'({N{1'b1}}));

    // R5 R9 round robin and per-channel order, R8 hold
    foreach (in_valid[c]) ;
    offer(0, 16, 256); offer(2, 18, 258); offer(5, 21, 261); tick();
    idle(); offer(0, 32, 512); offer(2, 34, 514); offer(5, 37, 517); tick();
    idle(); tick(); tick();
    held = out_data;
    chk("R5 first grant is channel 0", 64'(out_data), 64'(exp_hit(0, 16, 256)));
    tick();
    chk("R8 valid held under back-pressure", 64'(out_valid), 64'd1);
    chk("R8 data held under back-pressure", 64'(out_data), 64'(held));
    out_ready = 1'b1;
    repeat (10) tick();
    chk("R5 round robin word count", 64'(got.size()), 64'd6);
    if (got.size() == 6) begin
      chk("R5 rr word 0", 64'(got[0]), 64'(exp_hit(0, 16, 256)));
      chk("R5 rr word 1", 64'(got[1]), 64'(exp_hit(2, 18, 258)));
      chk("R5 rr word 2", 64'(got[2]), 64'(exp_hit(5, 21, 261)));
      chk("R9 rr word 3", 64'(got[3]), 64'(exp_hit(0, 32, 512)));
      chk("R9 rr word 4", 64'(got[4]), 64'(exp_hit(2, 34, 514)));
      chk("R9 rr word 5", 64'(got[5]), 64'(exp_hit(5, 37, 517)));
    end

    // R2 R4 header insertion and coalescing
    do_reset();
    slot = 5'd5;
    offer(1, 1, 1); offer(2, 2, 2); tick();
    idle(); tick();
    win_start = 1'b1; offer(4, 4, 4); tick();
    idle(); win_start = 1'b1; tick();
    idle(); tick(); tick();
    out_ready = 1'b1;
    repeat (8) tick();
    chk("R4 one header for two pulses", 64'(got.size()), 64'd4);
    if (got.size() == 4) begin
      chk("R4 held hit goes first", 64'(got[0]), 64'(exp_hit(1, 1, 1)));
      chk("R2 header word", 64'(got[1]), 64'h8000_8005);
      chk("R4 header before queued hits", 64'(got[2]), 64'(exp_hit(2, 2, 2)));
      chk("R4 hit after pulse follows header", 64'(got[3]), 64'(exp_hit(4, 4, 4)));
    end

    // R6 R7 overflow
    do_reset();
    for (int i = 0; i < D + 2; i++) begin
      idle(); offer(7, i, 100 + i); tick();
    end
    idle(); tick();
    chk("R7 ovf set on drop", 64'(ovf), 64'(1 << 7));
    chk("R6 in_ready low when full", 64'(in_ready[7]), 64'd0);
    out_ready = 1'b1;
    repeat (10) tick();
    chk("R6 dropped hit absent", 64'(got.size()), 64'(D + 1));
    for (int i = 0; i < D + 1 && i < got.size(); i++)
      chk("R6 kept hit order", 64'(got[i]), 64'(exp_hit(7, i, 100 + i)));
    chk("R7 ovf still set after drain", 64'(ovf), 64'(1 << 7));
    chk("R6 in_ready back after drain", 64'(in_ready[7]), 64'd1);

    // R10 full rate
    do_reset();
    out_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      idle(); offer(3, 50 + i, 9); tick();
    end
    idle(); tick();
    chk("R10 one word per cycle", 64'(got.size()), 64'd7);
    tick();
    chk("R10 all words out", 64'(got.size()), 64'd8);

    // mixed traffic against the model
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      idle();
      for (int c = 0; c < N; c++)
        if ($urandom_range(0, 7) == 0) offer(c, $urandom_range(0, 8191), $urandom_range(0, 16383));
      win_start = ($urandom_range(0, 40) == 0);
      out_ready = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 200) == 0) slot = 5'($urandom_range(3, 20));
      tick();
    end
    idle(); out_ready = 1'b1;
    repeat (80) tick();

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule